// File: doc/BRIEF.md
# Serial SRAM Burst Streaming Controller

This block is an SPI master that moves a burst of bytes into, or out of, an external serial SRAM of up to 128K bytes. The SRAM runs in sequential mode: after one instruction and one address it advances its own address after every byte. A client issues one command that gives the direction and the number of data bytes. The controller then drives chip select low, sends the instruction byte, sends a 24-bit start address of zero as three bytes, and streams the data bytes. Write data comes from a valid/ready byte stream and read data goes out on another.

The serial clock is the system clock divided by a parameter. The bus runs in SPI mode 0 with the most significant bit first. When the client cannot supply or take a byte, the controller pauses the serial clock between bytes and keeps chip select low. The memory therefore sees one unbroken sequential transfer.

Top module: `spi_sram_seq_ctrl`

## Requirements
- R1: After reset, cs_n is 1, sck is 0, cmd_ready is 1, wr_ready is 0 and rd_valid is 0.
- R2: The bus uses SPI mode 0 with MSB first. sck idles at 0, mosi changes only while sck is 0, and miso is sampled on the rising edge of sck.
- R3: Within a byte, consecutive rising edges of sck are 2*HALF_DIV system clock cycles apart.
- R4: Each burst has exactly one low period of cs_n. The first rising edge of sck comes at least HALF_DIV cycles after cs_n falls. cs_n rises at least HALF_DIV cycles after the last falling edge of sck. cs_n then stays high for at least HALF_DIV cycles before cmd_ready returns. sck is 0 whenever cs_n changes.
- R5: Every burst starts with an instruction byte and then three address bytes of 0x00. The instruction is 0x02 for a write and 0x03 for a read. The start address is zero, and the top 7 of the 24 address bits are zero.
- R6: A write burst takes exactly cmd_len bytes from the write stream, in order. A byte transfers in a cycle where wr_valid and wr_ready are both 1. Each byte is shifted out MSB first, so byte k lands at memory address k.
- R7: A read burst returns exactly cmd_len bytes, in address order, on rd_data. rd_valid and rd_data hold steady until a cycle with rd_ready at 1.
- R8: While the controller waits for a write byte or for a read byte to be accepted, sck stays at 0 and cs_n stays at 0. No bit is lost or repeated.
- R9: When cmd_len is 0, the burst carries only the instruction and address bytes and no data byte.
- R10: A command is accepted only in a cycle where cmd_valid and cmd_ready are both 1. cmd_ready is 0 for the whole burst, so cmd_valid raised during a burst starts no burst. cmd_ready is never 1 together with wr_ready or rd_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Burst command offered |
| cmd_ready | output | 1 | Controller idle, command can be taken |
| cmd_rd | input | 1 | 1 = read burst, 0 = write burst |
| cmd_len | input | LEN_W | Number of data bytes in the burst |
| wr_data | input | 8 | Write stream byte |
| wr_valid | input | 1 | Write stream byte present |
| wr_ready | output | 1 | Controller takes the write byte |
| rd_data | output | 8 | Read stream byte |
| rd_valid | output | 1 | Read stream byte present |
| rd_ready | input | 1 | Client takes the read byte |
| sck | output | 1 | Serial clock to the SRAM |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data to the SRAM |
| miso | input | 1 | Serial data from the SRAM |

## Verification
Two events can land on the same cycle. One is the client handshake on a byte stream. The other is the serial-clock divider reaching its terminal count, and both can fall while a new command is raised against a busy controller. The bench stalls wr_valid and rd_ready for a different number of cycles on each byte. This lines the handshakes up against divider ticks at different phases. It also holds cmd_valid high through the header of every write burst. The outcome is judged by a bench memory model that decodes the serial bus: the instruction, the address and every data byte must match patterns computed from the burst length, and the number of chip-select windows must equal the number of commands issued.

// File: rtl/spi_sram_pkg.sv
package spi_sram_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_GAP,
        ST_SHIFT,
        ST_HOLD,
        ST_REST
    } seq_state_e;

    localparam logic [7:0] OP_WRITE  = 8'h02;
    localparam logic [7:0] OP_READ   = 8'h03;
    localparam int         HDR_BYTES = 4;

endpackage

// File: rtl/sck_tick_gen.sv
module sck_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == CW'(DIV - 1));
        cnt_d = (clr || tick) ? '0 : cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [BW-1:0] load_byte,
    input  logic          rise,
    input  logic          fall,
    input  logic          miso,
    output logic          mosi,
    output logic [BW-1:0] rx_byte,
    output logic          last_fall
);
    localparam int CW = $clog2(BW);

    typedef struct packed {
        logic [BW-1:0] tx;
        logic [BW-1:0] rx;
        logic [CW-1:0] cnt;
    } shf_t;

    shf_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.tx  = load_byte;
            s_d.cnt = '0;
        end else begin
            if (rise) s_d.rx = {s_q.rx[BW-2:0], miso};
            if (fall) begin
                s_d.tx  = {s_q.tx[BW-2:0], 1'b0};
                s_d.cnt = s_q.cnt + CW'(1);
            end
        end
        mosi      = s_q.tx[BW-1];
        rx_byte   = s_q.rx;
        last_fall = fall && (s_q.cnt == CW'(BW - 1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/spi_sram_seq_ctrl.sv
module spi_sram_seq_ctrl
    import spi_sram_pkg::*;
#(
    parameter int HALF_DIV = 4,
    parameter int LEN_W    = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    output logic             cmd_ready,
    input  logic             cmd_rd,
    input  logic [LEN_W-1:0] cmd_len,
    input  logic [7:0]       wr_data,
    input  logic             wr_valid,
    output logic             wr_ready,
    output logic [7:0]       rd_data,
    output logic             rd_valid,
    input  logic             rd_ready,
    output logic             sck,
    output logic             cs_n,
    output logic             mosi,
    input  logic             miso
);
    localparam int HW = $clog2(HDR_BYTES + 1);

    typedef struct packed {
        seq_state_e       st;
        logic             sck;
        logic             cs_n;
        logic             rd;
        logic [LEN_W-1:0] rem;
        logic [HW-1:0]    hdr;
        logic             pend;
        logic [7:0]       rbuf;
    } ctl_t;

    ctl_t q, n;

    logic       tick, clr, load, rise, fall, last_fall;
    logic [7:0] load_byte, rx_byte;

    sck_tick_gen #(.DIV(HALF_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .tick  (tick)
    );

    spi_byte_shifter #(.BW(8)) u_shf (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_byte (load_byte),
        .rise      (rise),
        .fall      (fall),
        .miso      (miso),
        .mosi      (mosi),
        .rx_byte   (rx_byte),
        .last_fall (last_fall)
    );

    always_comb begin
        n         = q;
        clr       = 1'b0;
        load      = 1'b0;
        load_byte = '0;
        cmd_ready = 1'b0;
        wr_ready  = 1'b0;
        rise      = (q.st == ST_SHIFT) && tick && !q.sck;
        fall      = (q.st == ST_SHIFT) && tick &&  q.sck;

        case (q.st)
            ST_IDLE: begin
                cmd_ready = 1'b1;
                if (cmd_valid) begin
                    n.st   = ST_SETUP;
                    n.cs_n = 1'b0;
                    n.rd   = cmd_rd;
                    n.rem  = cmd_len;
                    n.hdr  = '0;
                    clr    = 1'b1;
                end
            end
            ST_SETUP: begin
                if (tick) n.st = ST_GAP;
            end
            ST_GAP: begin
                if (q.pend) begin
                    if (rd_ready) n.pend = 1'b0;
                end else if (q.hdr < HW'(HDR_BYTES)) begin
                    load      = 1'b1;
                    load_byte = (q.hdr == '0) ? (q.rd ? OP_READ : OP_WRITE) : 8'h00;
                    n.st      = ST_SHIFT;
                    clr       = 1'b1;
                end else if (q.rem != '0) begin
                    if (!q.rd) begin
                        wr_ready = 1'b1;
                        if (wr_valid) begin
                            load      = 1'b1;
                            load_byte = wr_data;
                            n.st      = ST_SHIFT;
                            clr       = 1'b1;
                        end
                    end else begin
                        load = 1'b1;
                        n.st = ST_SHIFT;
                        clr  = 1'b1;
                    end
                end else begin
                    n.st = ST_HOLD;
                    clr  = 1'b1;
                end
            end
            ST_SHIFT: begin
                if (tick) n.sck = !q.sck;
                if (last_fall) begin
                    n.st = ST_GAP;
                    if (q.hdr < HW'(HDR_BYTES)) begin
                        n.hdr = q.hdr + HW'(1);
                    end else begin
                        n.rem = q.rem - LEN_W'(1);
                        if (q.rd) begin
                            n.pend = 1'b1;
                            n.rbuf = rx_byte;
                        end
                    end
                end
            end
            ST_HOLD: begin
                if (tick) begin
                    n.cs_n = 1'b1;
                    n.st   = ST_REST;
                end
            end
            ST_REST: begin
                if (tick) n.st = ST_IDLE;
            end
            default: n.st = ST_IDLE;
        endcase

        sck      = q.sck;
        cs_n     = q.cs_n;
        rd_valid = (q.st == ST_GAP) && q.pend;
        rd_data  = q.rbuf;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.cs_n <= 1'b1;
        end else begin
            q <= n;
        end
    end
endmodule

// File: rtl/spi_sram_seq_chk.sv
module spi_sram_seq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_ready,
    input logic       wr_ready,
    input logic       rd_valid,
    input logic       rd_ready,
    input logic [7:0] rd_data,
    input logic       sck,
    input logic       cs_n,
    input logic       mosi
);
    a_r1_idle_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> cs_n);

    a_r2_sck_rests_low: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);

    a_r2_mosi_steady_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(mosi));

    a_r4_cs_edge_sck_low: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cs_n) || $fell(cs_n)) |-> !sck);

    a_r7_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

    a_r8_paused_clock: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid || wr_ready) |-> (!sck && !cs_n));

    a_r10_ready_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (!wr_ready && !rd_valid));
endmodule

bind spi_sram_seq_ctrl spi_sram_seq_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_ready (cmd_ready),
    .wr_ready  (wr_ready),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .rd_data   (rd_data),
    .sck       (sck),
    .cs_n      (cs_n),
    .mosi      (mosi)
);

// File: tb/tb_spi_sram_seq_ctrl.sv
module tb_spi_sram_seq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 2;
    localparam int LEN_W      = 6;
    localparam int MEM_N      = 512;
    localparam int NLEN       = 7;

    logic             clk = 1'b0, rst_n = 1'b0;
    logic             cmd_valid = 1'b0, cmd_rd = 1'b0;
    logic [LEN_W-1:0] cmd_len = '0;
    logic [7:0]       wr_data = '0;
    logic             wr_valid = 1'b0, rd_ready = 1'b0, miso = 1'b0;
    logic             cmd_ready, wr_ready, rd_valid, sck, cs_n, mosi;
    logic [7:0]       rd_data;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    spi_sram_seq_ctrl #(.HALF_DIV(DIV), .LEN_W(LEN_W)) dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_rd(cmd_rd), .cmd_len(cmd_len), .wr_data(wr_data), .wr_valid(wr_valid),
        .wr_ready(wr_ready), .rd_data(rd_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
        .sck(sck), .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // serial SRAM model
    logic [7:0]  mem [MEM_N];
    logic [7:0]  m_hdr [4];
    logic [7:0]  m_sh = '0;
    logic [16:0] m_addr = '0;
    int  m_bit = 0, m_byte = 0, m_cnt = 0, bursts = 0, per_err = 0, tim_err = 0, per_seen = 0;
    time t_cs_fall = 0, t_cs_rise = 0, t_rise = 0, t_fall = 0;

    always @(negedge cs_n) begin
        m_bit = 0; m_byte = 0; m_cnt = 0; bursts++; t_cs_fall = $time;
    end

    always @(posedge cs_n) begin
        if (t_fall != 0 && ($time - t_fall) < DIV * CLK_PERIOD) tim_err++;
        t_cs_rise = $time;
    end

    always @(posedge cmd_ready) begin
        if (t_cs_rise != 0 && ($time - t_cs_rise) < DIV * CLK_PERIOD) tim_err++;
    end

    always @(posedge sck) begin
        if (!cs_n) begin
            if (m_bit == 0 && m_byte == 0 && ($time - t_cs_fall) < DIV * CLK_PERIOD) tim_err++;
            if (m_bit != 0) begin
                per_seen++;
                if (($time - t_rise) != 2 * DIV * CLK_PERIOD) per_err++;
            end
            t_rise = $time;
            m_sh = {m_sh[6:0], mosi};
            m_bit++;
            if (m_bit == 8) begin
                m_bit = 0;
                if (m_byte < 4) m_hdr[m_byte] = m_sh;
                else begin
                    if (m_hdr[0] == 8'h02) mem[(int'(m_addr) + m_cnt) % MEM_N] = m_sh;
                    m_cnt++;
                end
                if (m_byte == 3) m_addr = {m_hdr[1][0], m_hdr[2], m_hdr[3]};
                m_byte++;
            end
        end
    end

    always @(negedge sck) begin
        t_fall = $time;
        if (!cs_n && m_hdr[0] == 8'h03 && m_byte >= 4)
            miso = mem[(int'(m_addr) + m_cnt) % MEM_N][7 - m_bit];
    end

    function automatic logic [7:0] pat(int len, int i);
        return 8'((len * 29 + i * 53 + 7) ^ (i << 3));
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic issue_cmd(bit rd, int len);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_rd = rd; cmd_len = LEN_W'(len);
        while (!cmd_ready) @(negedge clk);
        @(posedge clk); #1;
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!cmd_ready);
    endtask

    task automatic check_hdr(logic [7:0] op, int len);
        chk(m_hdr[0] == op, "R5 R2 instruction", int'(m_hdr[0]), int'(op));
        chk({m_hdr[1], m_hdr[2], m_hdr[3]} == 24'h0, "R5 address zero",
            int'({m_hdr[1], m_hdr[2], m_hdr[3]}), 0);
        chk(m_cnt == len, "R6 R7 R9 data byte count", m_cnt, len);
    endtask

    task automatic do_write(int len, int mode);
        issue_cmd(1'b0, len);
        if (len > 0) begin
            cmd_valid = 1'b1; cmd_rd = 1'b1;   // R10: raised while busy
        end
        for (int i = 0; i < len; i++) begin
            do @(negedge clk); while (!wr_ready);
            if (cmd_valid) chk(!cmd_ready, "R10 busy blocks command", int'(cmd_ready), 0);
            cmd_valid = 1'b0;
            for (int s = 0; s < (i * mode) % 4; s++) begin
                chk(!sck && !cs_n && wr_ready, "R8 write stall", int'({sck, cs_n}), 0);
                @(negedge clk);
            end
            wr_valid = 1'b1; wr_data = pat(len, i);
            @(posedge clk); #1;
            wr_valid = 1'b0;
        end
        wait_done();
        check_hdr(8'h02, len);
        for (int i = 0; i < len; i++)
            chk(mem[i] == pat(len, i), "R6 memory byte", int'(mem[i]), int'(pat(len, i)));
    endtask

    task automatic do_read(int len, int mode);
        issue_cmd(1'b1, len);
        for (int i = 0; i < len; i++) begin
            do @(negedge clk); while (!rd_valid);
            for (int s = 0; s < (i * mode + 1) % 3; s++) begin
                chk(!sck && !cs_n && rd_valid, "R8 read stall", int'({sck, cs_n}), 0);
                @(negedge clk);
            end
            chk(rd_data == pat(len, i), "R7 read byte", int'(rd_data), int'(pat(len, i)));
            rd_ready = 1'b1;
            @(posedge clk); #1;
            rd_ready = 1'b0;
        end
        wait_done();
        check_hdr(8'h03, len);
    endtask

    initial begin
        automatic int lens[NLEN] = '{0, 1, 2, 3, 5, 8, 13};
        for (int a = 0; a < MEM_N; a++) mem[a] = 8'hEE;
        for (int h = 0; h < 4; h++) m_hdr[h] = 8'h00;
        repeat (4) @(negedge clk);
        chk(cs_n == 1'b1, "R1 cs_n", int'(cs_n), 1);
        chk(sck == 1'b0, "R1 sck", int'(sck), 0);
        chk(cmd_ready == 1'b1, "R1 cmd_ready", int'(cmd_ready), 1);
        chk(!wr_ready && !rd_valid, "R1 stream flags", int'({wr_ready, rd_valid}), 0);
        rst_n = 1'b1;
        for (int li = 0; li < NLEN; li++) begin
            do_write(lens[li], li % 3);
            do_read(lens[li], (li + 1) % 3);
        end
        repeat (10) @(negedge clk);
        chk(bursts == 2 * NLEN, "R4 R10 burst count", bursts, 2 * NLEN);
        chk(per_seen > 0 && per_err == 0, "R3 sck period", per_err, 0);
        chk(tim_err == 0, "R4 cs setup/hold/rest", tim_err, 0);
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * CLK_PERIOD);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end
endmodule